// File: doc/BRIEF.md
# Pattern-Armed Divide-by-Four Enable Generator

This block watches a serial line whose bit cells last four system clock cycles. It brings the line into the system clock domain through a short register chain, marks every change of level in either direction, and keeps a two-bit phase counter that runs from 0 to 3. While the block is idle, every marked change restarts the counter, so the counter stays locked to the bit cells of the incoming stream. Once per cell, at phase 2, the resynchronized level is shifted into an eight-bit window. The window is then compared with a programmable sync word.

When the window equals the sync word, the block latches an armed state. From then on it produces two registered outputs. The first is a one-cycle enable pulse every fourth system cycle, which downstream logic can use as a clock enable at one quarter of the system rate. The second is a square wave with 50% duty cycle at the same rate. Once armed, the phase runs freely and ignores further line activity. A one-cycle disarm request, or a synchronous reset, returns the block to the idle search state and empties the window.

Top module: `seq_armed_div4`

## Requirements
- R1: `serial_in` passes through two register stages before the edge logic or the sampler sees it.
- R2: While unarmed, a change of the resynchronized level in either direction restarts the phase at 0 on the next clock edge.
- R3: The resynchronized level is sampled on the edge where the phase is 2. It is shifted into an 8-bit window from the top end, so the earliest of eight bits ends in bit 0. The window is compared with `SYNC_WORD`. With the default 8'h54, the bits must arrive in the order 0,0,1,0,1,0,1,0.
- R4: While unarmed, `tick_o` and `sq_o` stay low, including while near-miss patterns arrive.
- R5: Let t be the first clock edge on which `serial_in` carries the last bit of a matching word, with cells of four cycles aligned by R2. Then `sq_o` first goes high after edge t+7, and `tick_o` first pulses after edge t+10.
- R6: While armed, `tick_o` is a one-cycle pulse every fourth cycle. `sq_o` is high for two cycles and low for two, and `tick_o` coincides with the second low cycle.
- R7: While armed, transitions on `serial_in`, including cells of irregular length, do not move the output phase.
- R8: A `disarm` pulse has the outputs follow their normal pattern on the edge that samples the request, and drives them low from the next cycle on. The window is cleared, so a window that held the sync word when `disarm` was sampled does not re-arm the block; a full new word is needed.
- R9: With `rst` high, the outputs go low after the next clock edge and stay low. After release, the block arms again only on a full matching word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, four cycles per serial bit |
| rst | input | 1 | Synchronous active-high reset |
| serial_in | input | 1 | Asynchronous serial data line |
| disarm | input | 1 | One-cycle request to drop the armed state and clear the window |
| tick_o | output | 1 | Registered one-cycle enable pulse at one quarter of the clock rate |
| sq_o | output | 1 | Registered square wave at one quarter of the clock rate, 50% duty |

## Verification
The bench sends near-miss words before the real one. A window that is compared at the wrong phase, or bits taken in the reverse order, would arm on a decoy or never arm, and the first stray pulse shows it. The first rising cycle of the square wave and the first pulse are timed exactly, so a synchronizer stage too many or too few, or a sample point one cycle off, moves every predicted cycle. While the block is armed, cells of 2, 3, 5 and 6 cycles are sent, which would drift the pulses of a design that kept realigning. The bench also disarms exactly when the window holds the sync word, so a design that forgets to clear the window re-arms and emits pulses where none are due.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;

  // direction flags produced by the transition detector
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_flags_t;

  // default sync word, earliest received bit in bit 0
  localparam logic [7:0] DEF_SYNC_WORD = 8'h54;

endpackage

// File: rtl/sda_sync.sv
module sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/sda_edge.sv
module sda_edge
  import seq_div_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        level,
  output edge_flags_t flags
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level;
  end

  // both operands are register outputs, so the flags are glitch free
  always_comb begin
    flags.rise = level & ~prev_q;
    flags.fall = ~level & prev_q;
  end

endmodule

// File: rtl/sda_phase.sv
module sda_phase #(
  parameter int DIV = 4,
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          realign,
  output logic [CW-1:0] phase
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  always_ff @(posedge clk) begin
    if (rst)                phase <= '0;
    else if (realign)       phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                    phase <= phase + CW'(1);
  end

endmodule

// File: rtl/sda_window.sv
module sda_window #(
  parameter int                PAT_W     = 8,
  parameter logic [PAT_W-1:0]  SYNC_WORD = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sample,
  input  logic             bit_in,
  output logic [PAT_W-1:0] window,
  output logic             hit
);

  // new bits enter at the top; after PAT_W samples the earliest sits in bit 0
  always_ff @(posedge clk) begin
    if (rst || clr) window <= '0;
    else if (sample) window <= {bit_in, window[PAT_W-1:1]};
  end

  assign hit = (window == SYNC_WORD);

endmodule

// File: rtl/seq_armed_div4.sv
module seq_armed_div4
  import seq_div_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter int               DIV         = 4,
  parameter int               PAT_W       = 8,
  parameter logic [PAT_W-1:0] SYNC_WORD   = PAT_W'(DEF_SYNC_WORD)
) (
  input  logic clk,
  input  logic rst,
  input  logic serial_in,
  input  logic disarm,
  output logic tick_o,
  output logic sq_o
);

  localparam int              CW        = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0]   SAMPLE_PH = CW'(DIV / 2);
  localparam logic [CW-1:0]   LAST_PH   = CW'(DIV - 1);
  localparam logic [CW-1:0]   HALF_PH   = CW'(DIV / 2);

  logic             sync_bit;
  edge_flags_t      edges;
  logic             edge_seen;
  logic             armed_q;
  logic             realign;
  logic [CW-1:0]    phase;
  logic [PAT_W-1:0] window;
  logic             hit;

  sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (serial_in),
    .q   (sync_bit)
  );

  sda_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (sync_bit),
    .flags (edges)
  );

  assign edge_seen = edges.rise | edges.fall;
  assign realign   = ~armed_q & edge_seen;

  sda_phase #(.DIV(DIV)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .realign (realign),
    .phase   (phase)
  );

  sda_window #(.PAT_W(PAT_W), .SYNC_WORD(SYNC_WORD)) u_window (
    .clk    (clk),
    .rst    (rst),
    .clr    (disarm),
    .sample (phase == SAMPLE_PH),
    .bit_in (sync_bit),
    .window (window),
    .hit    (hit)
  );

  // sticky arm flag; disarm outranks a match in the same cycle
  always_ff @(posedge clk) begin
    if (rst)         armed_q <= 1'b0;
    else if (disarm) armed_q <= 1'b0;
    else if (hit)    armed_q <= 1'b1;
  end

  // registered outputs, gated by the arm flag acting as clock enable
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_o <= 1'b0;
      sq_o   <= 1'b0;
    end else begin
      tick_o <= armed_q && (phase == LAST_PH);
      sq_o   <= armed_q && (phase < HALF_PH);
    end
  end

endmodule

// File: rtl/seq_armed_div4_chk.sv
module seq_armed_div4_chk #(
  parameter int DIV   = 4,
  parameter int PAT_W = 8,
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             disarm,
  input logic             tick_o,
  input logic             sq_o,
  input logic             armed,
  input logic             edge_seen,
  input logic             sync_bit,
  input logic [CW-1:0]    phase,
  input logic [PAT_W-1:0] window
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] SMP  = CW'(DIV / 2);

  // R4: no output while unarmed
  a_r4_quiet_unarmed: assert property (@(posedge clk) disable iff (rst)
    !armed |=> (!tick_o && !sq_o));

  // R2: an edge while unarmed restarts the phase
  a_r2_realign: assert property (@(posedge clk) disable iff (rst)
    (!armed && edge_seen) |=> (phase == '0));

  // R7: armed phase advances freely
  a_r7_free_run: assert property (@(posedge clk) disable iff (rst)
    armed |=> (phase == (($past(phase) == LAST) ? '0 : $past(phase) + CW'(1))));

  // R3: sample at phase 2 enters at the top of the window
  a_r3_shift_in: assert property (@(posedge clk) disable iff (rst)
    (phase == SMP && !disarm) |=> (window[PAT_W-1] == $past(sync_bit)));

  // R6: pulse lies in a low half and lasts one cycle
  a_r6_tick_low_half: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> !sq_o);
  a_r6_tick_single: assert property (@(posedge clk) disable iff (rst)
    (tick_o && armed) |=> !tick_o);
  a_r6_sq_two_high: assert property (@(posedge clk) disable iff (rst)
    ($rose(sq_o) && armed) |=> sq_o);

  // R8: disarm drops the flag and empties the window
  a_r8_disarm_clears: assert property (@(posedge clk) disable iff (rst)
    disarm |=> (!armed && window == '0));

  // R9: reset forces outputs low
  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> (!tick_o && !sq_o && !armed));

endmodule

bind seq_armed_div4 seq_armed_div4_chk #(.DIV(DIV), .PAT_W(PAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .disarm    (disarm),
  .tick_o    (tick_o),
  .sq_o      (sq_o),
  .armed     (armed_q),
  .edge_seen (edge_seen),
  .sync_bit  (sync_bit),
  .phase     (phase),
  .window    (window)
);

// File: tb/test_seq_armed_div4.sv
module test_seq_armed_div4;

  localparam int          BIG = 32'h3fff_ffff;
  localparam logic [7:0]  PAT = 8'h54;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_in = 1'b1;
  logic disarm = 1'b0;
  logic tick_o, sq_o;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [7:0] m_win = '0;
  int  m_nbits = 0;
  bit  m_armed = 0;
  int  base = BIG;
  int  endc = BIG;
  int  exp_q[$];

  seq_armed_div4 i_seq_armed_div4 (
    .clk       (clk),
    .rst       (rst),
    .serial_in (serial_in),
    .disarm    (disarm),
    .tick_o    (tick_o),
    .sq_o      (sq_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", what, cyc, act, exp);
    end
  endtask

  function automatic bit exp_sq(input int c);
    if (c >= base && c <= endc) return ((c - base) % 4) < 2;
    return 1'b0;
  endfunction

  // drop predictions beyond the last cycle the outputs may still be active
  task automatic cut_after(input int last);
    while (exp_q.size() > 0 && exp_q[$] > last) void'(exp_q.pop_back());
  endtask

  // driver: called on a negedge, drives one bit for 'cells' cycles
  task automatic send_bit(input logic b, input int cells);
    serial_in = b;
    if (!m_armed) begin
      m_win = {b, m_win[7:1]};
      m_nbits++;
      if (m_nbits >= 8 && m_win == PAT) begin
        m_armed = 1;
        base = cyc + 8;          // R5: sq high after edge t+7, t = cyc+1
        endc = BIG;
        for (int n = 0; n < 64; n++) exp_q.push_back(base + 3 + 4 * n);
      end
    end
    repeat (cells) @(negedge clk);
  endtask

  task automatic send_word(input logic [7:0] w);
    for (int i = 0; i < 8; i++) send_bit(w[i], 4);
  endtask

  // monitor: pops expected pulses as the design produces them
  always @(negedge clk) begin : mon
    int e;
    while (exp_q.size() > 0 && exp_q[0] < cyc) begin
      e = exp_q.pop_front();
      chk(1'b0, "R6 missed tick_o", 0, e);
    end
    if (tick_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R4/R8/R9 unexpected tick_o", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(e == cyc, "R1/R5/R6/R7 tick_o cycle", cyc, e);
      end
    end
    chk(sq_o == exp_sq(cyc), "R4/R5/R6/R7/R8 sq_o level", int'(sq_o), int'(exp_sq(cyc)));
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : drive
    repeat (5) @(negedge clk);
    chk(tick_o == 1'b0 && sq_o == 1'b0, "R9 outputs low in reset", int'({tick_o, sq_o}), 0);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    // preamble, starts with a fall from idle high (R2 alignment)
    send_word(8'b0111_0110);
    // near misses (R3/R4)
    send_word(8'b1101_0100);
    send_word(8'b0101_0110);
    send_word(8'b0100_0100);
    send_bit(1'b1, 4);
    send_bit(1'b1, 4);
    chk(m_armed == 0, "R4 model stayed unarmed through decoys", int'(m_armed), 0);
    // real word: arms (R3/R5)
    send_word(PAT);
    chk(m_armed == 1, "R3 sync word recognised by model", int'(m_armed), 1);

    // armed: irregular cells totalling 16 cycles (R7)
    send_bit(1'b1, 2);
    send_bit(1'b0, 6);
    send_bit(1'b1, 3);
    send_bit(1'b0, 5);
    // window now receives the sync word again while armed
    send_word(PAT);
    // last bit sampled on edge c_last+6; disarm on that sample (R8)
    repeat (2) @(negedge clk);
    disarm = 1'b1;
    endc = cyc + 1;
    cut_after(cyc + 1);
    m_armed = 0; m_win = '0; m_nbits = 0;
    @(negedge clk);
    disarm = 1'b0;
    repeat (12) @(negedge clk);

    // re-arm needs a full fresh word (R8)
    send_bit(1'b1, 4);
    send_word(PAT);
    chk(m_armed == 1, "R8 re-arm after full word", int'(m_armed), 1);
    send_bit(1'b1, 4);
    send_bit(1'b1, 4);
    send_bit(1'b0, 4);
    send_bit(1'b1, 4);
    repeat (3) @(negedge clk);

    // reset while armed (R9)
    rst = 1'b1;
    endc = cyc;
    cut_after(cyc);
    m_armed = 0; m_win = '0; m_nbits = 0;
    repeat (2) @(negedge clk);
    chk(tick_o == 1'b0 && sq_o == 1'b0, "R9 outputs low after reset edge", int'({tick_o, sq_o}), 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // only a partial word after reset: must stay quiet (R9/R4)
    send_bit(1'b0, 4);
    send_bit(1'b0, 4);
    send_bit(1'b1, 4);
    send_bit(1'b0, 4);
    send_bit(1'b1, 4);
    send_bit(1'b0, 4);
    repeat (24) @(negedge clk);

    chk(exp_q.size() == 0, "R6 all predicted ticks seen", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule